// File: doc/BRIEF.md
# Capability Tag Controller

This block sits in front of a small data memory and keeps one hidden validity bit for every capability-sized, naturally aligned word. A capability store writes a word and sets that word's bit from the tag that comes with the store. Any ordinary data store clears the bit of every word it touches, partly or fully. Because of this, a value rebuilt from plain bytes never reads back as a valid capability. A capability load returns the word together with its bit. A plain load returns the raw row and never shows a tag.

The memory is organised in rows of `LANES` capability words, each `CAP_BYTES` bytes wide. Requests arrive on a valid/ready channel. Results leave on a second valid/ready channel, one response for every accepted request, in order. The response stage holds one entry. A new request is accepted when that stage is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and `req_ready` stays low. The data and tag effects of a request are written at its accepting clock edge.

Top module: `cap_tag_ctrl`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1 and every word's tag is 0, so a capability load of any word returns `rsp_tag` 0.
- R2: A capability store (`req_op` = 2'b11) to an address aligned to `CAP_BYTES` writes `req_wdata[CAP_W-1:0]` into the addressed word and sets that word's tag to `req_wtag`. A capability load (`req_op` = 2'b10) returns the word in `rsp_rdata[CAP_W-1:0]`, zeros above it, and the word's tag on `rsp_tag`.
- R3: A data store (`req_op` = 2'b01) writes each byte of the row whose `req_be` bit is set. Byte b of the row is `rsp_rdata[8b+7:8b]`. Word l of a row covers bytes l*CAP_BYTES to l*CAP_BYTES+CAP_BYTES-1, and its index is `req_addr` bits [log2(BUS_BYTES)-1 : log2(CAP_BYTES)]. The row is given by the address bits above those. The store clears the tag of every word with at least one enabled byte and leaves the tags of the other words as they were.
- R4: A data store with an all-zero `req_be` changes neither data nor tags.
- R5: A data load (`req_op` = 2'b00) returns the whole addressed row on `rsp_rdata`, and `rsp_tag` is 0 whatever tags the row holds.
- R6: A capability load or store whose address is not a multiple of `CAP_BYTES` gets a response with `rsp_err` 1, `rsp_rdata` 0 and `rsp_tag` 0, and leaves data and tags unchanged. Every other response has `rsp_err` 0.
- R7: `req_ready` is high exactly when no response is pending or `rsp_ready` is high. Each accepted request produces one response in the next cycle. A stalled response holds its values. Store responses carry `rsp_rdata` 0 and `rsp_tag` 0.
- R8: A request accepted in the cycle right after a store sees that store's data and tag updates.
- R9: A capability store with `req_wtag` 0 clears a tag that was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 00 data load, 01 data store, 10 capability load, 11 capability store |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | BUS_W | Store data; capability stores use the low CAP_W bits |
| req_be | input | BUS_BYTES | Byte enables for data stores |
| req_wtag | input | 1 | Tag written by a capability store |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_rdata | output | BUS_W | Load data, zero for stores and errors |
| rsp_tag | output | 1 | Tag of a capability load, else 0 |
| rsp_err | output | 1 | Misaligned capability access |

## Verification
Some checks run on every cycle inside the RTL. A set tag lands where the store aimed it. A cleared word reads as untagged afterwards. Set and clear never happen in the same cycle. Misaligned or byte-less stores leave the tag vector untouched. A stalled response holds its values, and error responses are empty. Other behaviour can only be shown by the bench's scenarios, which run against a byte-level model. These cover whether the right bytes land in the right row, and whether a partial store clears exactly the touched words. They also show that a plain load hides the tag, that a load issued right behind a store observes it, and that responses stay correct under an irregular `rsp_ready` pattern.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;
  typedef enum logic [1:0] {
    OP_LOAD      = 2'b00,
    OP_STORE     = 2'b01,
    OP_CAP_LOAD  = 2'b10,
    OP_CAP_STORE = 2'b11
  } mem_op_e;
endpackage

// File: rtl/tagmem_decode.sv
module tagmem_decode
  import tagmem_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int CAP_BYTES = 8,
  parameter int LANES     = 2,
  localparam int BUS_BYTES = CAP_BYTES * LANES,
  localparam int BUS_W     = BUS_BYTES * 8,
  localparam int CAP_W     = CAP_BYTES * 8,
  localparam int OFF_W     = $clog2(CAP_BYTES),
  localparam int BOFF_W    = $clog2(BUS_BYTES),
  localparam int ROW_W     = $clog2(ROWS),
  localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int ADDR_W    = BOFF_W + ROW_W
) (
  input  logic                 go,
  input  mem_op_e              op,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BUS_BYTES-1:0] be,
  input  logic [BUS_W-1:0]     wdata,
  input  logic                 wtag,
  output logic [ROW_W-1:0]     row,
  output logic [LANE_W-1:0]    lane,
  output logic                 misalign,
  output logic [BUS_BYTES-1:0] byte_we,
  output logic [BUS_W-1:0]     wbus,
  output logic                 tag_set_en,
  output logic                 tag_set_val,
  output logic [LANES-1:0]     tag_clr
);
  logic                 is_cap;
  logic                 commit;
  logic [BUS_BYTES-1:0] cap_mask;
  logic [LANES-1:0]     lane_touch;

  assign row      = addr[BOFF_W +: ROW_W];
  assign is_cap   = (op == OP_CAP_LOAD) || (op == OP_CAP_STORE);
  assign misalign = is_cap && (addr[OFF_W-1:0] != '0);
  assign commit   = go && !misalign;

  generate
    if (LANES > 1) begin : g_lane_sel
      assign lane = addr[BOFF_W-1:OFF_W];
    end else begin : g_one_lane
      logic unused_off;
      assign unused_off = ^addr[BOFF_W-1:0];
      assign lane = '0;
    end
  endgenerate

  for (genvar l = 0; l < LANES; l++) begin : g_lanes
    assign cap_mask[l*CAP_BYTES +: CAP_BYTES] = {CAP_BYTES{lane == LANE_W'(l)}};
    assign lane_touch[l] = |be[l*CAP_BYTES +: CAP_BYTES];
  end

  always_comb begin
    byte_we     = '0;
    wbus        = wdata;
    tag_set_en  = 1'b0;
    tag_set_val = 1'b0;
    tag_clr     = '0;
    if (commit) begin
      unique case (op)
        OP_STORE: begin
          byte_we = be;
          tag_clr = lane_touch;
        end
        OP_CAP_STORE: begin
          byte_we     = cap_mask;
          wbus        = {LANES{wdata[CAP_W-1:0]}};
          tag_set_en  = 1'b1;
          tag_set_val = wtag;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tagmem_data_array.sv
module tagmem_data_array #(
  parameter int ROWS      = 16,
  parameter int BUS_BYTES = 16,
  localparam int BUS_W    = BUS_BYTES * 8,
  localparam int ROW_W    = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic [ROW_W-1:0]     row,
  input  logic [BUS_BYTES-1:0] byte_we,
  input  logic [BUS_W-1:0]     wbus,
  output logic [BUS_W-1:0]     rdata
);
  logic [BUS_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < BUS_BYTES; b++) begin
      if (byte_we[b]) mem[row][b*8 +: 8] <= wbus[b*8 +: 8];
    end
  end

  assign rdata = mem[row];
endmodule

// File: rtl/tagmem_tag_array.sv
module tagmem_tag_array #(
  parameter int ROWS  = 16,
  parameter int LANES = 2,
  localparam int WORDS  = ROWS * LANES,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  row,
  input  logic [LANE_W-1:0] lane,
  input  logic              set_en,
  input  logic              set_val,
  input  logic [LANES-1:0]  clr,
  output logic              rd_tag,
  output logic [WORDS-1:0]  tags_q
);
  int set_idx;
  assign set_idx = int'(row) * LANES + int'(lane);
  assign rd_tag  = tags_q[set_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tags_q <= '0;
    end else begin
      if (set_en) tags_q[set_idx] <= set_val;
      for (int l = 0; l < LANES; l++) begin
        if (clr[l]) tags_q[int'(row) * LANES + l] <= 1'b0;
      end
    end
  end

  // R2: the written tag value is the one found in the word afterwards
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> tags_q[$past(set_idx)] == $past(set_val));

  // R3: every word named in a clear mask reads untagged afterwards
  a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((tags_q >> ($past(int'(row)) * LANES)) & WORDS'($past(clr))) == '0);

  // R3: a request never both sets and clears tags
  a_r3_set_clear_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && (clr != '0)));
endmodule

// File: rtl/cap_tag_ctrl.sv
module cap_tag_ctrl
  import tagmem_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int CAP_BYTES = 8,
  parameter int LANES     = 2,
  localparam int BUS_BYTES = CAP_BYTES * LANES,
  localparam int BUS_W     = BUS_BYTES * 8,
  localparam int CAP_W     = CAP_BYTES * 8,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int ADDR_W    = $clog2(BUS_BYTES) + ROW_W,
  localparam int WORDS     = ROWS * LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [BUS_W-1:0]     req_wdata,
  input  logic [BUS_BYTES-1:0] req_be,
  input  logic                 req_wtag,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [BUS_W-1:0]     rsp_rdata,
  output logic                 rsp_tag,
  output logic                 rsp_err
);
  mem_op_e              op;
  logic                 accept;
  logic [ROW_W-1:0]     d_row;
  logic [LANE_W-1:0]    d_lane;
  logic                 d_misalign;
  logic [BUS_BYTES-1:0] d_byte_we;
  logic [BUS_W-1:0]     d_wbus;
  logic                 d_set_en;
  logic                 d_set_val;
  logic [LANES-1:0]     d_clr;
  logic [BUS_W-1:0]     row_data;
  logic                 word_tag;
  logic [WORDS-1:0]     tag_vec;
  logic [CAP_W-1:0]     cap_word;
  logic [BUS_W-1:0]     cap_ext;
  logic [BUS_W-1:0]     nxt_data;
  logic                 nxt_tag;
  logic                 nxt_err;
  logic                 rsp_valid_q;
  logic [BUS_W-1:0]     rsp_data_q;
  logic                 rsp_tag_q;
  logic                 rsp_err_q;

  assign op        = mem_op_e'(req_op);
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  tagmem_decode #(.ROWS(ROWS), .CAP_BYTES(CAP_BYTES), .LANES(LANES)) u_decode (
    .go(accept), .op(op), .addr(req_addr), .be(req_be), .wdata(req_wdata),
    .wtag(req_wtag), .row(d_row), .lane(d_lane), .misalign(d_misalign),
    .byte_we(d_byte_we), .wbus(d_wbus), .tag_set_en(d_set_en),
    .tag_set_val(d_set_val), .tag_clr(d_clr)
  );

  tagmem_data_array #(.ROWS(ROWS), .BUS_BYTES(BUS_BYTES)) u_data (
    .clk(clk), .row(d_row), .byte_we(d_byte_we), .wbus(d_wbus), .rdata(row_data)
  );

  tagmem_tag_array #(.ROWS(ROWS), .LANES(LANES)) u_tags (
    .clk(clk), .rst_n(rst_n), .row(d_row), .lane(d_lane), .set_en(d_set_en),
    .set_val(d_set_val), .clr(d_clr), .rd_tag(word_tag), .tags_q(tag_vec)
  );

  assign cap_word = row_data[int'(d_lane) * CAP_W +: CAP_W];

  always_comb begin
    cap_ext = '0;
    cap_ext[CAP_W-1:0] = cap_word;
  end

  always_comb begin
    nxt_data = '0;
    nxt_tag  = 1'b0;
    nxt_err  = 1'b0;
    if (d_misalign) begin
      nxt_err = 1'b1;
    end else begin
      unique case (op)
        OP_LOAD:     nxt_data = row_data;
        OP_CAP_LOAD: begin
          nxt_data = cap_ext;
          nxt_tag  = word_tag;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_tag_q   <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= nxt_data;
      rsp_tag_q   <= nxt_tag;
      rsp_err_q   <= nxt_err;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign rsp_tag   = rsp_tag_q;
  assign rsp_err   = rsp_err_q;

  // R7: an accepted request always yields a response next cycle
  a_r7_accept_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R7: a stalled response keeps its contents
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)
                                   && $stable(rsp_tag) && $stable(rsp_err)));

  // R6: a misaligned capability access leaves every tag alone
  a_r6_err_keeps_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && d_misalign) |=> $stable(tag_vec));

  // R6: error responses carry no data and no tag
  a_r6_err_rsp_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (!rsp_tag && rsp_rdata == '0));

  // R4: a data store with no enabled byte leaves every tag alone
  a_r4_empty_be_keeps_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_STORE && req_be == '0) |=> $stable(tag_vec));
endmodule

// File: tb/cap_tag_ctrl_bench.sv
module cap_tag_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 16;
  localparam int CAP_BYTES = 8;
  localparam int LANES = 2;
  localparam int BUS_BYTES = CAP_BYTES * LANES;
  localparam int BUS_W = BUS_BYTES * 8;
  localparam int CAP_W = CAP_BYTES * 8;
  localparam int ADDR_W = 8;

  typedef struct {
    logic [BUS_W-1:0] data;
    logic             tag;
    logic             err;
    logic             chk_data;
    string            req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BUS_W-1:0] req_wdata = '0;
  logic [BUS_BYTES-1:0] req_be = '0;
  logic req_wtag = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [BUS_W-1:0] rsp_rdata;
  logic rsp_tag;
  logic rsp_err;

  int checks = 0;
  int errors = 0;
  bit bp = 1'b0;
  bit done = 1'b0;
  int bp_cnt = 0;
  exp_t expq[$];
  logic [BUS_W-1:0] mdl_data [ROWS];
  logic mdl_tag [ROWS*LANES];

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_tag_ctrl #(.ROWS(ROWS), .CAP_BYTES(CAP_BYTES), .LANES(LANES)) u_cap_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_wtag(req_wtag), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag), .rsp_err(rsp_err)
  );

  function automatic logic [ADDR_W-1:0] mk_addr(int row, int lane, int off);
    return ADDR_W'(row * BUS_BYTES + lane * CAP_BYTES + off);
  endfunction

  task automatic check(input bit ok, input string what, input logic [BUS_W-1:0] act,
                       input logic [BUS_W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  // Driver: presents one request, updates the model at acceptance, queues the expectation
  task automatic send(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                      input logic [BUS_W-1:0] wd, input logic [BUS_BYTES-1:0] be,
                      input logic wt, input bit chk_data, input string rq);
    exp_t e;
    int row, lane;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr;
    req_wdata = wd; req_be = be; req_wtag = wt;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    row  = int'(addr) / BUS_BYTES;
    lane = (int'(addr) % BUS_BYTES) / CAP_BYTES;
    e.data = '0; e.tag = 1'b0; e.err = 1'b0; e.chk_data = chk_data; e.req = rq;
    if (op[1] && (int'(addr) % CAP_BYTES) != 0) begin
      e.err = 1'b1;
      e.chk_data = 1'b1;
    end else begin
      case (op)
        2'b00: e.data = mdl_data[row];
        2'b01: begin
          for (int b = 0; b < BUS_BYTES; b++)
            if (be[b]) mdl_data[row][b*8 +: 8] = wd[b*8 +: 8];
          for (int l = 0; l < LANES; l++)
            if (be[l*CAP_BYTES +: CAP_BYTES] != '0) mdl_tag[row*LANES + l] = 1'b0;
        end
        2'b10: begin
          e.data[CAP_W-1:0] = mdl_data[row][lane*CAP_W +: CAP_W];
          e.tag = mdl_tag[row*LANES + lane];
        end
        default: begin
          mdl_data[row][lane*CAP_W +: CAP_W] = wd[CAP_W-1:0];
          mdl_tag[row*LANES + lane] = wt;
        end
      endcase
    end
    expq.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: drives the response back-pressure, then compares each delivered response
  logic stalled = 1'b0;
  logic [BUS_W-1:0] st_data;
  logic st_tag, st_err;
  always @(negedge clk) begin
    exp_t e;
    bp_cnt++;
    rsp_ready = bp ? ((bp_cnt % 3) != 0) : 1'b1;
    #2;
    if (rst_n) begin
      if (stalled) begin
        check(rsp_valid && rsp_rdata === st_data && rsp_tag === st_tag && rsp_err === st_err,
              "R7 stalled response held", rsp_rdata, st_data);
      end
      stalled = rsp_valid && !rsp_ready;
      st_data = rsp_rdata; st_tag = rsp_tag; st_err = rsp_err;
      if (rsp_valid && rsp_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7 response without request", rsp_rdata, '0);
        end else begin
          e = expq.pop_front();
          check(rsp_err === e.err, {e.req, " err"}, BUS_W'(rsp_err), BUS_W'(e.err));
          check(rsp_tag === e.tag, {e.req, " tag"}, BUS_W'(rsp_tag), BUS_W'(e.tag));
          if (e.chk_data)
            check(rsp_rdata === e.data, {e.req, " data"}, rsp_rdata, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [BUS_W-1:0] pat;
    for (int r = 0; r < ROWS*LANES; r++) mdl_tag[r] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #3;
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset handshake state",
          BUS_W'({req_ready, rsp_valid}), BUS_W'(2'b10));

    // R1: all tags clear after reset (data still undefined)
    for (int r = 0; r < ROWS; r++)
      for (int l = 0; l < LANES; l++)
        send(2'b10, mk_addr(r, l, 0), '0, '0, 1'b0, 1'b0, "R1 reset tag");

    // R5/R3: fill rows with full-width data stores, read them back
    for (int r = 0; r < ROWS; r++) begin
      pat = {4{32'hA5000000 + 32'(r * 32'h01010101)}};
      send(2'b01, mk_addr(r, 0, 0), pat, '1, 1'b0, 1'b1, "R3 fill store");
    end
    for (int r = 0; r < ROWS; r++)
      send(2'b00, mk_addr(r, 1, 5), '0, '0, 1'b0, 1'b1, "R5 row load");

    // R2/R8: capability stores then immediate loads
    send(2'b11, mk_addr(2, 0, 0), {64'hFFFF, 64'h1122334455667788}, '0, 1'b1, 1'b1, "R2 cap store");
    send(2'b10, mk_addr(2, 0, 0), '0, '0, 1'b0, 1'b1, "R8 cap load after store");
    send(2'b11, mk_addr(2, 1, 0), {64'h0, 64'hCAFEF00DDEADBEEF}, '0, 1'b1, 1'b1, "R2 cap store lane1");
    send(2'b10, mk_addr(2, 1, 0), '0, '0, 1'b0, 1'b1, "R2 cap load lane1");
    send(2'b00, mk_addr(2, 0, 0), '0, '0, 1'b0, 1'b1, "R5 data load hides tag");

    // R3: partial store touching only word 0
    send(2'b01, mk_addr(2, 0, 0), {BUS_W/8{8'h3C}}, 16'h0001, 1'b0, 1'b1, "R3 one byte store");
    send(2'b10, mk_addr(2, 0, 0), '0, '0, 1'b0, 1'b1, "R3 touched word cleared");
    send(2'b10, mk_addr(2, 1, 0), '0, '0, 1'b0, 1'b1, "R3 untouched word kept");
    send(2'b11, mk_addr(3, 0, 0), 128'h77, '0, 1'b1, 1'b1, "R2 cap store row3 w0");
    send(2'b11, mk_addr(3, 1, 0), 128'h99, '0, 1'b1, 1'b1, "R2 cap store row3 w1");
    send(2'b01, mk_addr(3, 0, 0), {BUS_W/8{8'h5A}}, 16'h0180, 1'b0, 1'b1, "R3 straddling store");
    send(2'b10, mk_addr(3, 0, 0), '0, '0, 1'b0, 1'b1, "R3 straddle clears w0");
    send(2'b10, mk_addr(3, 1, 0), '0, '0, 1'b0, 1'b1, "R3 straddle clears w1");

    // R4: empty byte enables
    send(2'b11, mk_addr(4, 1, 0), 128'h4444, '0, 1'b1, 1'b1, "R2 cap store row4");
    send(2'b01, mk_addr(4, 1, 0), '1, 16'h0000, 1'b0, 1'b1, "R4 empty store");
    send(2'b10, mk_addr(4, 1, 0), '0, '0, 1'b0, 1'b1, "R4 tag and data kept");
    send(2'b00, mk_addr(4, 0, 0), '0, '0, 1'b0, 1'b1, "R4 row unchanged");

    // R6: misaligned capability accesses
    send(2'b11, mk_addr(4, 1, 3), 128'hBAD, '0, 1'b0, 1'b1, "R6 misaligned cap store");
    send(2'b10, mk_addr(4, 1, 0), '0, '0, 1'b0, 1'b1, "R6 word unchanged");
    send(2'b10, mk_addr(4, 0, 7), '0, '0, 1'b0, 1'b1, "R6 misaligned cap load");

    // R9: capability store with a clear tag
    send(2'b11, mk_addr(4, 1, 0), 128'h5555, '0, 1'b0, 1'b1, "R9 cap store tag0");
    send(2'b10, mk_addr(4, 1, 0), '0, '0, 1'b0, 1'b1, "R9 tag cleared");

    // R7: irregular back-pressure
    bp = 1'b1;
    for (int i = 0; i < 12; i++) begin
      send(2'b11, mk_addr(5 + i % 4, i % 2, 0), 128'(i * 32'h01020304), '0, i[0], 1'b1, "R7 bp cap store");
      send(2'b10, mk_addr(5 + i % 4, i % 2, 0), '0, '0, 1'b0, 1'b1, "R7 bp cap load");
      send(2'b00, mk_addr(5 + i % 4, 0, 0), '0, '0, 1'b0, 1'b1, "R7 bp row load");
    end
    idle();
    bp = 1'b0;
    for (int w = 0; w < 50 && expq.size() != 0; w++) @(posedge clk);
    repeat (3) @(posedge clk);
    check(expq.size() == 0, "R7 all responses delivered", BUS_W'(expq.size()), '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule